// File: doc/BRIEF.md
# Bit-Masked Single-Port Weight Memory Port

This block is a synchronous model of the digital access port that sits in front of a small weight array of 32 rows by 32 bits. A bus master presents an enable, a test-mode flag, a read/write select, a full 32-bit address, write data and a per-bit write mask. The port acts only when the address matches one fixed trigger value. All other addresses are ignored, so the block can share a wide address space without a separate decoder.

The port has no row address. It keeps an internal row pointer that starts at row 0 and moves to the next row after every completed access, wrapping at the last row. A write changes only the bits whose mask bit is set. The registered output bus shows the written data after a write and the stored row after a read. It keeps its previous value in every cycle without an access. Each access completes in one clock cycle, and the result is visible after the capturing edge.

Top module: `bitmask_wmem`

## Requirements
- R1: While `rst` is high at a rising edge, every array row, the output register `rdData` and the row pointer are cleared to zero. No access takes place in that cycle.
- R2: An access happens at a rising edge only when `en`=1, `testMode`=0 and `addr`=32'h3000_0004. In any other cycle `rdData` keeps its value and the array is unchanged.
- R3: `rdNotWr`=1 selects a read and `rdNotWr`=0 selects a write.
- R4: On a write, the stored row takes bit i of `wrData` wherever bit i of `wrMask` is 1. It keeps its old bit wherever the mask bit is 0.
- R5: After a write edge, `rdData` equals the full unmasked `wrData` of that write.
- R6: After a read edge, `rdData` equals the contents of the row that the pointer selected for that access.
- R7: The row pointer starts at 0 and advances by one after each completed access, wrapping from 31 to 0. It does not move in cycles without an access.
- R8: With `testMode`=1, no read or write takes place, even when all other access conditions hold.
- R9: Every access completes in one cycle, and its effect on `rdData` is visible right after the capturing rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Port enable |
| testMode | input | 1 | Test mode; blocks all accesses when high |
| rdNotWr | input | 1 | 1 = read, 0 = write |
| addr | input | 32 | Address, compared against the trigger value |
| wrData | input | 32 | Write data |
| wrMask | input | 32 | Per-bit write enable, active high |
| rdData | output | 32 | Registered output bus |

## Verification
The main function is exercised with full-mask, partial-mask and single-byte-mask writes over rows that already hold data. Comparing the read-back with the old contents shows whether the masked bits merge correctly or whether the write overwrites the whole row. Each blocking condition is tried on its own: wrong address, test mode, and enable low. The output must hold through each of these, and the pointer must not move, which is checked later by which row a read returns. Long runs of reads carry the pointer past row 31 to check the wrap. A reset in the middle of the run, with an access request held during it, checks that the array is cleared and that no access occurs while reset is high.

// File: rtl/bitmask_wmem_pkg.sv
package bitmask_wmem_pkg;

  // Strobes passed from control to datapath for one cycle.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } strobe_t;

endpackage

// File: rtl/bitmask_wmem_ctrl.sv
module bitmask_wmem_ctrl
  import bitmask_wmem_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          ROWS   = 32,
  parameter logic [31:0] TRIG   = 32'h3000_0004,
  parameter int          PTR_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              testMode,
  input  logic              rdNotWr,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic [PTR_W-1:0]  rowSel
);

  localparam logic [PTR_W-1:0]  LAST_ROW = PTR_W'(ROWS - 1);
  localparam logic [ADDR_W-1:0] TRIG_A   = ADDR_W'(TRIG);

  logic accessOk;
  logic [PTR_W-1:0] rowPtr;

  always_comb begin
    accessOk  = en && !testMode && (addr == TRIG_A);
    stb.wrStb = accessOk && !rdNotWr;
    stb.rdStb = accessOk && rdNotWr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowPtr <= '0;
    end else if (accessOk) begin
      if (rowPtr == LAST_ROW) rowPtr <= '0;
      else                    rowPtr <= rowPtr + PTR_W'(1);
    end
  end

  assign rowSel = rowPtr;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((stb.wrStb || stb.rdStb) && rowSel != LAST_ROW) |=> rowSel == $past(rowSel) + PTR_W'(1)); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((stb.wrStb || stb.rdStb) && rowSel == LAST_ROW) |=> rowSel == '0); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(stb.wrStb || stb.rdStb) |=> $stable(rowSel)); // R7
  AST_PTR_RST: assert property (@(posedge clk)
    rst |=> rowSel == '0); // R1

endmodule

// File: rtl/bitmask_wmem_dp.sv
module bitmask_wmem_dp
  import bitmask_wmem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROWS   = 32,
  parameter int PTR_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [PTR_W-1:0]  rowSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMask,
  output logic [DATA_W-1:0] rdData
);

  logic [ROWS-1:0][DATA_W-1:0] rowQ;
  logic [DATA_W-1:0] selRow;
  logic [DATA_W-1:0] outQ;

  // One register per row, each with its own write enable.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DATA_W-1:0] cellQ;
    logic rowHit;
    assign rowHit = stb.wrStb && (rowSel == PTR_W'(r));
    always_ff @(posedge clk) begin
      if (rst)         cellQ <= '0;
      else if (rowHit) cellQ <= (cellQ & ~wrMask) | (wrData & wrMask);
    end
    assign rowQ[r] = cellQ;
  end

  assign selRow = rowQ[rowSel];

  always_ff @(posedge clk) begin
    if (rst)            outQ <= '0;
    else if (stb.wrStb) outQ <= wrData;
    else if (stb.rdStb) outQ <= selRow;
  end

  assign rdData = outQ;

  AST_WR_ECHO: assert property (@(posedge clk) disable iff (rst)
    stb.wrStb |=> rdData == $past(wrData)); // R5
  AST_RD_ROW: assert property (@(posedge clk) disable iff (rst)
    stb.rdStb |=> rdData == $past(selRow)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(stb.wrStb || stb.rdStb) |=> $stable(rdData)); // R2
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    stb.wrStb |=> ((rowQ[$past(rowSel)] ^ $past(selRow)) & ~$past(wrMask)) == '0); // R4
  AST_OUT_RST: assert property (@(posedge clk)
    rst |=> rdData == '0); // R1

endmodule

// File: rtl/bitmask_wmem.sv
module bitmask_wmem
  import bitmask_wmem_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter int          ROWS   = 32,
  parameter logic [31:0] TRIG   = 32'h3000_0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              testMode,
  input  logic              rdNotWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMask,
  output logic [DATA_W-1:0] rdData
);

  localparam int PTR_W = $clog2(ROWS);

  strobe_t          stb;
  logic [PTR_W-1:0] rowSel;

  bitmask_wmem_ctrl #(
    .ADDR_W(ADDR_W), .ROWS(ROWS), .TRIG(TRIG), .PTR_W(PTR_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .en(en), .testMode(testMode),
    .rdNotWr(rdNotWr), .addr(addr), .stb(stb), .rowSel(rowSel)
  );

  bitmask_wmem_dp #(
    .DATA_W(DATA_W), .ROWS(ROWS), .PTR_W(PTR_W)
  ) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .rowSel(rowSel),
    .wrData(wrData), .wrMask(wrMask), .rdData(rdData)
  );

endmodule

// File: tb/bitmask_wmem_tb_top.sv
module bitmask_wmem_tb_top;

  localparam logic [31:0] TRIG = 32'h3000_0004;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic        testMode;
  logic        rdNotWr;
  logic [31:0] addr;
  logic [31:0] wrData;
  logic [31:0] wrMask;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] refMem [32];
  int          refPtr;
  logic [31:0] refOut;

  bitmask_wmem dut_i (
    .clk(clk), .rst(rst), .en(en), .testMode(testMode), .rdNotWr(rdNotWr),
    .addr(addr), .wrData(wrData), .wrMask(wrMask), .rdData(rdData)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic        en;
    logic        tm;
    logic        rw;
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] m;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Starting from a cleared array and pointer 0.
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 1'b0, TRIG,         32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 8'd5}, // R5 row0 full write
    '{1'b1, 1'b0, 1'b0, TRIG,         32'hFFFF_0000, 32'h0F0F_0F0F, 32'hFFFF_0000, 8'd5}, // R5 row1 <= 0F0F0000
    '{1'b1, 1'b0, 1'b1, 32'h3000_0000, 32'h0,        32'h0,         32'hFFFF_0000, 8'd2}, // R2 wrong address
    '{1'b1, 1'b1, 1'b1, TRIG,         32'h0,         32'h0,         32'hFFFF_0000, 8'd8}, // R8 test mode
    '{1'b0, 1'b0, 1'b0, TRIG,         32'h1111_1111, 32'hFFFF_FFFF, 32'hFFFF_0000, 8'd2}, // R2 enable low
    '{1'b1, 1'b0, 1'b0, 32'h3000_0005, 32'h2222_2222, 32'hFFFF_FFFF, 32'hFFFF_0000, 8'd2}, // R2 near address write
    '{1'b1, 1'b0, 1'b1, TRIG,         32'h0,         32'h0,         32'h0000_0000, 8'd6}, // R6 row2 read, zero
    '{1'b1, 1'b0, 1'b0, TRIG,         32'h0000_00C3, 32'h0000_00FF, 32'h0000_00C3, 8'd3}  // R3 row3 write select
  };

  task automatic model_step(input logic e, input logic t, input logic rw,
                            input logic [31:0] a, input logic [31:0] d,
                            input logic [31:0] m);
    if (e && !t && a == TRIG) begin
      if (!rw) begin
        refMem[refPtr] = (refMem[refPtr] & ~m) | (d & m);
        refOut = d;
      end else begin
        refOut = refMem[refPtr];
      end
      refPtr = (refPtr == 31) ? 0 : refPtr + 1;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) refMem[i] = '0;
    refPtr = 0;
    refOut = '0;
  endtask

  // Drive at negedge, capture at posedge, sample at the following negedge.
  task automatic apply(input logic e, input logic t, input logic rw,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic [31:0] m);
    en = e; testMode = t; rdNotWr = rw; addr = a; wrData = d; wrMask = m;
    model_step(e, t, rw, a, d, m);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%08h expected=%08h", req, rdData, exp);
    end
  endtask

  task automatic do_read(input string req);
    apply(1'b1, 1'b0, 1'b1, TRIG, 32'h0, 32'h0);
    check(req, refOut);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; testMode = 1'b0; rdNotWr = 1'b1;
    addr = '0; wrData = '0; wrMask = '0;
    model_reset();
    @(negedge clk); @(negedge clk);
    check("R1", 32'h0);               // R1 reset state of output
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < 8; i++) begin
      apply(VECS[i].en, VECS[i].tm, VECS[i].rw, VECS[i].a, VECS[i].d, VECS[i].m);
      check($sformatf("R%0d/R9 vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R7: read rows 4..31, then the pointer wraps to row 0.
    for (int i = 4; i < 32; i++) do_read("R7");
    do_read("R7 wrap to row0");
    check("R7 row0 value", 32'hA5A5_A5A5);

    // R4: partial write on row1 (holding 0F0F0000).
    apply(1'b1, 1'b0, 1'b0, TRIG, 32'h1234_5678, 32'h0000_00FF);
    check("R5 echo", 32'h1234_5678);
    for (int i = 2; i < 32; i++) do_read("R6");
    do_read("R6 row0");
    do_read("R4 row1 merge");
    check("R4 row1 expect", 32'h0F0F_0078);
    do_read("R4 row2");
    do_read("R4 row3 byte mask");
    check("R4 row3 expect", 32'h0000_00C3);

    // R1: reset mid-run with an access request held.
    rst = 1'b1;
    apply(1'b1, 1'b0, 1'b0, TRIG, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    model_reset();
    check("R1 output cleared", 32'h0);
    rst = 1'b0;
    do_read("R1 row0 cleared");
    check("R1 row0 zero", 32'h0);
    apply(1'b1, 1'b0, 1'b0, TRIG, 32'hCAFE_F00D, 32'hFFFF_0000);
    check("R3 write after reset", 32'hCAFE_F00D);
    for (int i = 2; i < 32; i++) do_read("R7");
    do_read("R7 row0");
    do_read("R4 row1 upper half");
    check("R4 row1 upper expect", 32'hCAFE_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule